// File: doc/BRIEF.md
# Iterative Unsigned Multiply-Step Multiplier

This block multiplies two unsigned operands and returns a product twice their width. It does not use an array multiplier. It runs a chain of multiply steps, one step per clock, in the manner of a signed multiply-step datapath. A partial-product register and a Y register hold the working state. Each step works as follows:

- The partial product shifts right by one bit.
- The bit shifted into its top is the exclusive-or of the previous step's negative and overflow flags.
- The multiplicand is added when the low bit of Y is one.
- The bit that falls out of the partial product moves into the top of Y.

After the last add step, one extra step adds nothing and only shifts. Two lengths of run are possible. When both operands fit in `SHORT_W` bits, a short run of `SHORT_W` add steps is used, and the result is realigned from the two registers. Otherwise the block runs `W` add steps. On that long run, a compensation add fixes the signed-step result for an unsigned multiplicand whose top bit is set.

A caller waits for `ready_o`, presents both operands with a one-cycle `start`, and receives a one-cycle `done_o`. The product and an upper-word-zero flag stay on the outputs until the next accepted start.

Top module: `umul_seq`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0, `product_o` is 0 and `hi_zero_o` is 1.
- R2: A `start` sampled high while `ready_o` is 1 is accepted. `ready_o` falls on the next cycle. `done_o` is high for exactly one cycle, and `ready_o` is 1 in that same cycle.
- R3: The short path is taken when bits `SHORT_W` to `W-1` of both operands are all zero, and the long path otherwise. `done_o` rises `SHORT_W+2` clock edges after the accepting edge on the short path and `W+2` edges after it on the long path (14 and 34 with the defaults).
- R4: On the long path, `product_o` equals the full unsigned product of `mplier_i` and `mcand_i`. This holds also when the top bit of either operand is set.
- R5: On the short path, `product_o` equals the unsigned product, and its upper `W` bits are zero.
- R6: When `done_o` is 1, `hi_zero_o` is 1 exactly when bits `2W-1` to `W` of `product_o` are all zero. A 0 marks a product that does not fit in `W` bits.
- R7: `product_o` and `hi_zero_o` do not change between a `done_o` pulse and the next accepted start.
- R8: A `start` while `ready_o` is 0 is ignored. The run in progress completes with its own operands and its own timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled while ready |
| mplier_i | input | W | Multiplier operand, loaded into Y |
| mcand_i | input | W | Multiplicand operand, added on each step |
| ready_o | output | 1 | Idle and able to accept a start |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 2W | Unsigned product, upper word in the top half |
| hi_zero_o | output | 1 | Upper word of the product is zero |

## Verification
The bench builds the block with its default parameters, `W = 32` and `SHORT_W = 12`. With these values the path threshold falls between 0xFFF and 0x1000. The long run then needs 33 steps, enough to reach the compensation add for multiplicands of 0x80000000 and above. At this width every step of the sign-flag feedback is exercised, including sums that overflow as signed values. The short-path realignment is tested across its full 24-bit result range.

// File: rtl/umul_pkg.sv
package umul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } umul_state_e;

  // Number of add steps for a run; the trailing shift-only step is extra.
  function automatic int unsigned add_steps(input bit is_short, input int unsigned w,
                                            input int unsigned s);
    return is_short ? s : w;
  endfunction

endpackage

// File: rtl/umul_path_sel.sv
module umul_path_sel #(
  parameter int unsigned W       = 32,
  parameter int unsigned SHORT_W = 12,
  parameter int unsigned CW      = 6
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  output logic          is_short,
  output logic [CW-1:0] step_cnt
);
  import umul_pkg::*;

  localparam logic [W-1:0] LOW_MASK = (W'(1) << SHORT_W) - W'(1);

  function automatic logic fits_short(input logic [W-1:0] a, input logic [W-1:0] b);
    return ((a | b) & ~LOW_MASK) == '0;
  endfunction

  always_comb begin
    is_short = fits_short(op_a, op_b);
    // Counter counts down to zero; zero marks the shift-only step.
    step_cnt = CW'(add_steps(is_short, W, SHORT_W));
  end

endmodule

// File: rtl/umul_step_unit.sv
module umul_step_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         shift_only,
  input  logic [W-1:0] load_y,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] pp_o,
  output logic [W-1:0] y_o
);

  logic [W-1:0] pp_q, y_q;
  logic         nv_q;

  logic [W-1:0] shifted, addend, sum;
  logic         add_ovf;

  // Signed overflow of a two-operand add.
  function automatic logic signed_ovf(input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic [W-1:0] s);
    return (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
  endfunction

  always_comb begin
    shifted = {nv_q, pp_q[W-1:1]};
    addend  = (y_q[0] && !shift_only) ? mcand : '0;
    sum     = shifted + addend;
    add_ovf = signed_ovf(shifted, addend, sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_q <= '0;
      y_q  <= '0;
      nv_q <= 1'b0;
    end else if (load) begin
      pp_q <= '0;
      y_q  <= load_y;
      nv_q <= 1'b0;
    end else if (step) begin
      pp_q <= sum;
      y_q  <= {pp_q[0], y_q[W-1:1]};
      nv_q <= sum[W-1] ^ add_ovf;
    end
  end

  assign pp_o = pp_q;
  assign y_o  = y_q;

endmodule

// File: rtl/umul_result_fix.sv
module umul_result_fix #(
  parameter int unsigned W       = 32,
  parameter int unsigned SHORT_W = 12
) (
  input  logic [W-1:0] pp,
  input  logic [W-1:0] y,
  input  logic         is_short,
  input  logic         mcand_msb,
  input  logic [W-1:0] mplier,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);

  // Long run: the step chain treated the multiplicand top bit as a sign.
  function automatic logic [W-1:0] long_upper(input logic [W-1:0] p, input logic msb,
                                              input logic [W-1:0] m);
    return p + (msb ? m : '0);
  endfunction

  // Short run: the product is split across partial product and Y top bits.
  function automatic logic [W-1:0] short_lower(input logic [W-1:0] p, input logic [W-1:0] yy);
    return (p << SHORT_W) | (yy >> (W - SHORT_W));
  endfunction

  always_comb begin
    if (is_short) begin
      hi = '0;
      lo = short_lower(pp, y);
    end else begin
      hi = long_upper(pp, mcand_msb, mplier);
      lo = y;
    end
  end

endmodule

// File: rtl/umul_seq.sv
module umul_seq #(
  parameter int unsigned W       = 32,
  parameter int unsigned SHORT_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mplier_i,
  input  logic [W-1:0]   mcand_i,
  output logic           ready_o,
  output logic           done_o,
  output logic [2*W-1:0] product_o,
  output logic           hi_zero_o
);
  import umul_pkg::*;

  localparam int unsigned CW = $clog2(W + 2);

  umul_state_e    state_q;
  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   mcand_q, mplier_q;
  logic           short_q;
  logic [2*W-1:0] product_q;
  logic           hz_q, done_q;

  // Named internal events
  logic           load_evt, step_evt, last_step, fix_evt;
  logic           sel_short;
  logic [CW-1:0]  sel_cnt;
  logic [W-1:0]   pp_w, y_w, hi_w, lo_w;

  assign load_evt  = (state_q == ST_IDLE) && start;
  assign step_evt  = (state_q == ST_RUN);
  assign last_step = step_evt && (cnt_q == '0);
  assign fix_evt   = (state_q == ST_FIX);

  umul_path_sel #(.W(W), .SHORT_W(SHORT_W), .CW(CW)) u_sel (
    .op_a     (mplier_i),
    .op_b     (mcand_i),
    .is_short (sel_short),
    .step_cnt (sel_cnt)
  );

  umul_step_unit #(.W(W)) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_evt),
    .step       (step_evt),
    .shift_only (last_step),
    .load_y     (mplier_i),
    .mcand      (mcand_q),
    .pp_o       (pp_w),
    .y_o        (y_w)
  );

  umul_result_fix #(.W(W), .SHORT_W(SHORT_W)) u_fix (
    .pp        (pp_w),
    .y         (y_w),
    .is_short  (short_q),
    .mcand_msb (mcand_q[W-1]),
    .mplier    (mplier_q),
    .hi        (hi_w),
    .lo        (lo_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      mcand_q   <= '0;
      mplier_q  <= '0;
      short_q   <= 1'b0;
      product_q <= '0;
      hz_q      <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (load_evt) begin
          mcand_q  <= mcand_i;
          mplier_q <= mplier_i;
          short_q  <= sel_short;
          cnt_q    <= sel_cnt;
          state_q  <= ST_RUN;
        end
        ST_RUN: begin
          if (last_step) state_q <= ST_FIX;
          else           cnt_q   <= cnt_q - CW'(1);
        end
        ST_FIX: begin
          product_q <= {hi_w, lo_w};
          hz_q      <= (hi_w == '0);
          done_q    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign done_o    = done_q;
  assign product_o = product_q;
  assign hi_zero_o = hz_q;

endmodule

// File: rtl/umul_chk.sv
module umul_chk #(
  parameter int unsigned W       = 32,
  parameter int unsigned SHORT_W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           ready_o,
  input logic           done_o,
  input logic [2*W-1:0] product_o,
  input logic           hi_zero_o,
  input logic           load_evt,
  input logic           fix_evt,
  input logic           short_q,
  input logic [W-1:0]   mcand_q
);

  int unsigned cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= 0;
    else if (load_evt) cyc <= 0;
    else if (!ready_o) cyc <= cyc + 1;
  end

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start) |=> !ready_o);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc == (short_q ? SHORT_W + 2 : W + 2)));

  assert_short_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && short_q) |-> (product_o[2*W-1:W] == '0));

  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (hi_zero_o == (product_o[2*W-1:W] == '0)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_evt |=> ($stable(product_o) && $stable(hi_zero_o)));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && start) |=> $stable(mcand_q));

endmodule

bind umul_seq umul_chk #(.W(W), .SHORT_W(SHORT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ready_o   (ready_o),
  .done_o    (done_o),
  .product_o (product_o),
  .hi_zero_o (hi_zero_o),
  .load_evt  (load_evt),
  .fix_evt   (fix_evt),
  .short_q   (short_q),
  .mcand_q   (mcand_q)
);

// File: tb/sim_umul_seq.sv
`timescale 1ns/1ps
module sim_umul_seq;
  localparam int W  = 32;
  localparam int SW = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mplier = '0, mcand = '0;
  logic           ready, done, hz;
  logic [2*W-1:0] prod;

  int checks = 0, fails = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;   // 50 MHz

  umul_seq #(.W(W), .SHORT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mplier_i(mplier), .mcand_i(mcand),
    .ready_o(ready), .done_o(done), .product_o(prod), .hi_zero_o(hz)
  );

  task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act,
                     input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  // Launch a multiply; optionally pulse start again while busy.
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit busy_poke, input string tag);
    logic [2*W-1:0] exp_p;
    int exp_cyc, n;
    bit is_short;
    exp_p    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    is_short = (a < (1 << SW)) && (b < (1 << SW));
    exp_cyc  = is_short ? SW + 2 : W + 2;
    @(negedge clk);
    mplier = a; mcand = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(ready == 1'b0, {"R2 ready drops ", tag}, 64'(ready), 64'd0);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (busy_poke && n == 4) begin
        mplier = ~a; mcand = ~b; start = 1'b1;
      end else start = 1'b0;
      if (done) break;
    end
    chk(n == exp_cyc, {"R3 latency ", tag}, 64'(n), 64'(exp_cyc));
    chk(prod == exp_p, {is_short ? "R5 short product " : "R4 long product ", tag}, prod, exp_p);
    chk(hz == (exp_p[2*W-1:W] == 0), {"R6 hi_zero ", tag}, 64'(hz), 64'(exp_p[2*W-1:W] == 0));
    chk(ready == 1'b1, {"R2 ready with done ", tag}, 64'(ready), 64'd1);
    @(negedge clk);
    chk(done == 1'b0, {"R2 done one cycle ", tag}, 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    chk(ready == 1'b1, "R1 ready", 64'(ready), 64'd1);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    chk(prod == '0, "R1 product", prod, '0);
    chk(hz == 1'b1, "R1 hi_zero", 64'(hz), 64'd1);
  endtask

  task automatic t_short();
    run_mul(32'h0, 32'h0, 0, "zero");
    run_mul(32'hFFF, 32'hFFF, 0, "fff*fff");
    run_mul(32'd1, 32'hABC, 0, "1*abc");
    run_mul(32'h800, 32'h7FF, 0, "800*7ff");
  endtask

  task automatic t_boundary();
    run_mul(32'h1000, 32'h1, 0, "1000*1");
    run_mul(32'hFFF, 32'h1000, 0, "fff*1000");
    run_mul(32'h1000, 32'h1000, 0, "1000*1000");
  endtask

  task automatic t_topbit();
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "max*max");
    run_mul(32'h3, 32'h8000_0000, 0, "3*msb");
    run_mul(32'h8000_0000, 32'h5, 0, "msb*5");
    run_mul(32'h8000_0001, 32'hC000_0003, 0, "both msb");
  endtask

  task automatic t_random();
    for (int i = 0; i < 20; i++) run_mul(next_rand(), next_rand(), 0, "random");
    for (int i = 0; i < 6; i++) run_mul(next_rand() & 32'hFFF, next_rand() & 32'hFFF, 0, "rand short");
  endtask

  task automatic t_busy_hold();
    logic [2*W-1:0] kept;
    logic kept_hz;
    run_mul(32'h0001_2345, 32'h9876_5432, 1, "R8 busy start ignored");
    kept = prod; kept_hz = hz;
    repeat (7) @(negedge clk);
    chk(prod == kept, "R7 product held", prod, kept);
    chk(hz == kept_hz, "R7 flag held", 64'(hz), 64'(kept_hz));
    run_mul(32'h77, 32'h99, 1, "R8 busy start on short run");
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_boundary();
    t_topbit();
    t_random();
    t_busy_hold();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    summary();
  end

endmodule